// File: doc/BRIEF.md
# Multiplexed Parallel Slave Port Front End

This block connects a host's 16-bit parallel bus to an internal word-addressed store. The bus carries both addresses and data. The host places a word address on the low lines and pulses the address-latch strobe. The block keeps that address for as many reads and writes as follow. It does not step the address after an access. The address changes only when the host pulses the latch strobe again, or when the block is reset.

Writes can target the low byte, the high byte or the whole word. The host may signal a write in either of two ways, chosen by a static style pin. In the first, it uses two separate write strobes, one per byte. In the second, it uses a read/write select together with two byte-lane enables. If the host ties both byte selects together, they act as one word-write strobe.

Word addresses 3F00h to 3FFFh reach a control-register bank. All lower addresses reach a buffer RAM, which wraps modulo its depth. Reads return the stored word one clock after the read request. The block drives the shared bus only while chip select and a read are both active and the latch strobe is low.

Top module: `mpsp_front`

## Requirements
- R1: On a falling edge of `ale`, the latch loads bits 13:0 of the `ad_in` value that was present in the last cycle `ale` was high. Bits 15:14 of the bus take no part in the address.
- R2: The latched address does not change on a read or a write, and it is not incremented. It changes only on a new `ale` falling edge or on reset. Repeated accesses therefore reach the same word.
- R3: A synchronous reset (`rst` high) clears the latched address to 0. Stored words are kept through reset.
- R4: With `style`=0, a write happens when `sel`=1 and `ale`=0. `wr_lo` writes `ad_in[7:0]` to bits 7:0 of the addressed word. `wr_hi` writes `ad_in[15:8]` to bits 15:8. Both together write the whole word.
- R5: With `style`=1, the write enables are `rw`=1 together with `lane_lo` (bits 7:0) and `lane_hi` (bits 15:8). When `rw`=0 with any lane set, the cycle is a read and never a write.
- R6: While `sel`=0, no write takes place and `ad_oe` stays 0.
- R7: `ad_oe` is 1 only in a cycle with `sel`=1, `ale`=0 and a read request, and not when a write is requested in the same cycle. A read request is `rd`=1 with `style`=0, or `rw`=0 with a lane set when `style`=1. During that cycle, `ad_out` holds the word that was at the latched address at the clock edge where the request was first sampled.
- R8: Word addresses 3F00h to 3FFFh reach a 256-word control bank, indexed by address bits 7:0. Lower addresses reach the buffer RAM at the address modulo `BUF_DEPTH`. The two stores never alias each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| style | input | 1 | Write signalling style: 0 = separate byte strobes, 1 = read/write select with lane enables |
| sel | input | 1 | Chip select, active high |
| ale | input | 1 | Address-latch strobe; the address loads on its falling edge |
| rd | input | 1 | Read strobe (style 0) |
| wr_lo | input | 1 | Low-byte write strobe (style 0) |
| wr_hi | input | 1 | High-byte write strobe (style 0) |
| rw | input | 1 | 1 = write, 0 = read (style 1) |
| lane_lo | input | 1 | Low byte-lane enable (style 1) |
| lane_hi | input | 1 | High byte-lane enable (style 1) |
| ad_in | input | 16 | Shared bus value as seen at the pads |
| ad_out | output | 16 | Read data driven toward the pads |
| ad_oe | output | 1 | Pad output enable for the shared bus |

## Verification
Bytes are written in both signalling styles with every lane combination: low only, high only, both, and neither. Reading back the whole word shows whether each lane landed in the right half and left the other half alone. Addresses are chosen in pairs that share their low bits but sit in different regions (0305h and 3F05h), or that alias inside the buffer (0105h and 2105h). This shows whether the region decode separates the control bank from the buffer, and whether the buffer wraps as modelled. Some sequences issue several accesses after a single latch strobe, put junk on the upper bus lines, or pulse reset between accesses. These show whether the address is held, is never incremented, and is masked to 14 bits. Deselected writes and reads during an active latch strobe are also tried, to show whether the pad enable and the write path stay quiet.

// File: rtl/mpsp_pkg.sv
package mpsp_pkg;

  localparam int BUS_W = 16;
  localparam int LANES = BUS_W / 8;

  typedef enum logic {
    STYLE_SPLIT = 1'b0,
    STYLE_LANES = 1'b1
  } wr_style_e;

  // Byte enables wanted by the host, before chip-select gating.
  function automatic logic [LANES-1:0] lane_pick(input wr_style_e s,
                                                 input logic wl, input logic wh,
                                                 input logic rw, input logic ll,
                                                 input logic lh);
    if (s == STYLE_SPLIT) return {wh, wl};
    return rw ? {lh, ll} : '0;
  endfunction

  // Read request, before gating.
  function automatic logic read_pick(input wr_style_e s, input logic rd,
                                     input logic rw, input logic ll,
                                     input logic lh);
    if (s == STYLE_SPLIT) return rd;
    return !rw && (ll || lh);
  endfunction

  // First word address of the control region at the top of the space.
  function automatic int unsigned ctrl_base(input int unsigned addr_w,
                                            input int unsigned ctrl_words);
    return (32'd1 << addr_w) - ctrl_words;
  endfunction

endpackage

// File: rtl/mpsp_addr_latch.sv
module mpsp_addr_latch #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [ADDR_W-1:0] bus_lo,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              ale_fall
);

  logic              ale_q;
  logic [ADDR_W-1:0] bus_q;

  assign ale_fall = ale_q & ~ale;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q    <= 1'b0;
      bus_q    <= '0;
      lat_addr <= '0;
    end else begin
      ale_q <= ale;
      bus_q <= bus_lo;
      if (ale_fall) lat_addr <= bus_q;
    end
  end

endmodule

// File: rtl/mpsp_strobe_decode.sv
module mpsp_strobe_decode
  import mpsp_pkg::*;
(
  input  logic             style,
  input  logic             sel,
  input  logic             ale,
  input  logic             rd,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             rw,
  input  logic             lane_lo,
  input  logic             lane_hi,
  output logic [LANES-1:0] we,
  output logic             re
);

  wr_style_e        mode;
  logic [LANES-1:0] want;
  logic             rq;
  logic             gate;

  always_comb begin
    mode = wr_style_e'(style);
    want = lane_pick(mode, wr_lo, wr_hi, rw, lane_lo, lane_hi);
    rq   = read_pick(mode, rd, rw, lane_lo, lane_hi);
    gate = sel & ~ale;
    we   = gate ? want : '0;
    // a write request in the same cycle takes precedence over a read
    re   = gate & rq & ~(|want);
  end

endmodule

// File: rtl/mpsp_store.sv
module mpsp_store #(
  parameter int ADDR_W     = 14,
  parameter int BUF_DEPTH  = 1024,
  parameter int CTRL_WORDS = 256,
  parameter int LANES      = 2
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  we,
  input  logic [8*LANES-1:0] wdata,
  input  logic              re,
  output logic [8*LANES-1:0] rdata
);

  localparam int BUF_AW  = $clog2(BUF_DEPTH);
  localparam int CTRL_AW = $clog2(CTRL_WORDS);
  localparam int unsigned BASE = mpsp_pkg::ctrl_base(ADDR_W, CTRL_WORDS);

  logic               is_ctrl;
  logic [BUF_AW-1:0]  b_idx;
  logic [CTRL_AW-1:0] c_idx;

  assign is_ctrl = (addr >= ADDR_W'(BASE));
  assign b_idx   = addr[BUF_AW-1:0];
  assign c_idx   = addr[CTRL_AW-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] buf_m [BUF_DEPTH];
    logic [7:0] ctl_m [CTRL_WORDS];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[l]) begin
        if (is_ctrl) ctl_m[c_idx] <= wdata[8*l +: 8];
        else         buf_m[b_idx] <= wdata[8*l +: 8];
      end
      if (re) rd_q <= is_ctrl ? ctl_m[c_idx] : buf_m[b_idx];
    end

    assign rdata[8*l +: 8] = rd_q;
  end

endmodule

// File: rtl/mpsp_front.sv
module mpsp_front #(
  parameter int ADDR_W     = 14,
  parameter int BUF_DEPTH  = 1024,
  parameter int CTRL_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        style,
  input  logic        sel,
  input  logic        ale,
  input  logic        rd,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        rw,
  input  logic        lane_lo,
  input  logic        lane_hi,
  input  logic [15:0] ad_in,
  output logic [15:0] ad_out,
  output logic        ad_oe
);

  localparam int LANES = mpsp_pkg::LANES;

  // named internal events, observed by the bound checker
  logic [ADDR_W-1:0] lat_addr;
  logic              ale_fall;
  logic [LANES-1:0]  we;
  logic              re;

  mpsp_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .ale      (ale),
    .bus_lo   (ad_in[ADDR_W-1:0]),
    .lat_addr (lat_addr),
    .ale_fall (ale_fall)
  );

  mpsp_strobe_decode u_dec (
    .style   (style),
    .sel     (sel),
    .ale     (ale),
    .rd      (rd),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .rw      (rw),
    .lane_lo (lane_lo),
    .lane_hi (lane_hi),
    .we      (we),
    .re      (re)
  );

  mpsp_store #(
    .ADDR_W     (ADDR_W),
    .BUF_DEPTH  (BUF_DEPTH),
    .CTRL_WORDS (CTRL_WORDS),
    .LANES      (LANES)
  ) u_store (
    .clk   (clk),
    .addr  (lat_addr),
    .we    (we),
    .wdata (ad_in),
    .re    (re),
    .rdata (ad_out)
  );

  assign ad_oe = re;

endmodule

// File: rtl/mpsp_front_chk.sv
module mpsp_front_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              ale,
  input logic              style,
  input logic              rw,
  input logic [ADDR_W-1:0] bus_lo,
  input logic              ad_oe,
  input logic [ADDR_W-1:0] lat_addr,
  input logic              ale_fall,
  input logic [1:0]        we
);

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    ale_fall |=> lat_addr == $past(bus_lo, 2)); // R1

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ale_fall |=> $stable(lat_addr)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> lat_addr == '0); // R3

  AST_LANE_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (style && !rw) |-> we == 2'b00); // R5

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sel |-> (we == 2'b00 && !ad_oe)); // R6

  AST_STROBE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (!ad_oe && we == 2'b00)); // R7

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (we != 2'b00) |-> !ad_oe); // R7

endmodule

bind mpsp_front mpsp_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel      (sel),
  .ale      (ale),
  .style    (style),
  .rw       (rw),
  .bus_lo   (ad_in[ADDR_W-1:0]),
  .ad_oe    (ad_oe),
  .lat_addr (lat_addr),
  .ale_fall (ale_fall),
  .we       (we)
);

// File: tb/test_mpsp_front.sv
module test_mpsp_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        style = 1'b0, sel = 1'b0, ale = 1'b0, rd = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0, rw = 1'b0, lane_lo = 1'b0, lane_hi = 1'b0;
  logic [15:0] ad_in = 16'h0;
  logic [15:0] ad_out;
  logic        ad_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [13:0] cur;
  logic [15:0] m_ctrl [256];
  logic [15:0] m_buf  [1024];

  always #10 clk = ~clk;  // 50 MHz

  mpsp_front i_mpsp_front (
    .clk(clk), .rst(rst), .style(style), .sel(sel), .ale(ale), .rd(rd),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rw(rw), .lane_lo(lane_lo), .lane_hi(lane_hi),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  // ---- reference model ----
  function automatic bit in_regs(input logic [13:0] a);
    return int'(a) >= 'h3F00;
  endfunction

  function automatic logic [15:0] m_rd(input logic [13:0] a);
    if (in_regs(a)) return m_ctrl[int'(a) - 'h3F00];
    return m_buf[int'(a) % 1024];
  endfunction

  task automatic m_wr(input logic [13:0] a, input logic [15:0] d,
                      input bit lo, input bit hi);
    logic [15:0] w;
    w = m_rd(a);
    if (lo) w[7:0]  = d[7:0];
    if (hi) w[15:8] = d[15:8];
    if (in_regs(a)) m_ctrl[int'(a) - 'h3F00] = w;
    else            m_buf[int'(a) % 1024]    = w;
  endtask

  function automatic logic [13:0] pool(input int i);
    case (i)
      0: return 14'h0000;  1: return 14'h0105;
      2: return 14'h2105;  3: return 14'h0305;
      4: return 14'h3EFF;  5: return 14'h3F00;
      6: return 14'h3F05;  default: return 14'h3FFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // ---- bus tasks: inputs change at falling edges ----
  task automatic idle();
    sel = 0; ale = 0; rd = 0; wr_lo = 0; wr_hi = 0; rw = 0; lane_lo = 0; lane_hi = 0;
  endtask

  task automatic latch(input logic [13:0] a, input logic [1:0] upper);
    @(negedge clk); idle(); ale = 1; ad_in = {upper, a};
    @(negedge clk); ale = 0; ad_in = 16'($urandom);
    cur = a;
  endtask

  task automatic wr_split(input logic [15:0] d, input bit lo, input bit hi, input bit cs);
    @(negedge clk); idle(); style = 0; sel = cs; wr_lo = lo; wr_hi = hi; ad_in = d;
    if (cs) m_wr(cur, d, lo, hi);
    @(negedge clk); idle();
  endtask

  task automatic wr_lanes(input logic [15:0] d, input bit lo, input bit hi);
    @(negedge clk); idle(); style = 1; sel = 1; rw = 1; lane_lo = lo; lane_hi = hi; ad_in = d;
    m_wr(cur, d, lo, hi);
    @(negedge clk); idle();
  endtask

  task automatic rd_word(input bit st, input string req);
    logic [15:0] exp;
    exp = m_rd(cur);
    @(negedge clk); idle(); style = st; sel = 1;
    if (st) begin rw = 0; lane_lo = 1; end else rd = 1;
    @(negedge clk);
    chk({req, " oe"}, 32'(ad_oe), 32'd1);
    chk({req, " data"}, 32'(ad_out), 32'(exp));
    idle();
  endtask

  // ---- watchdog ----
  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---- main sequence ----
  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R3 oe at reset", 32'(ad_oe), 32'd0);
    rst = 0;

    // prime every pool word with a full-word write
    for (int i = 0; i < 8; i++) begin
      latch(pool(i), 2'b00);
      wr_split(16'h1000 + 16'(i * 16'h0111), 1, 1, 1);
    end

    // R1: upper bus bits are masked off the address
    latch(14'h3F05, 2'b11);
    rd_word(0, "R1 masked upper bits");
    latch(14'h0105, 2'b10);
    rd_word(1, "R1 latch then lane read");

    // R4: split-style byte strobes
    latch(14'h0305, 2'b00);
    wr_split(16'hAB12, 1, 0, 1);
    rd_word(0, "R4 low byte only");
    wr_split(16'h34CD, 0, 1, 1);
    rd_word(0, "R4 high byte only");
    wr_split(16'h5A5A, 1, 1, 1);
    rd_word(0, "R4 tied strobes word write");
    // R2: several accesses without relatch stay on one word
    rd_word(0, "R2 repeated read same word");
    rd_word(1, "R2 no auto increment");

    // R5: lane-style writes
    latch(14'h3FFF, 2'b01);
    wr_lanes(16'hC3F0, 1, 0);
    rd_word(1, "R5 lane low");
    wr_lanes(16'h9E77, 0, 1);
    rd_word(1, "R5 lane high");
    wr_lanes(16'h0F0F, 1, 1);
    rd_word(0, "R5 both lanes");
    // rw=0 with lanes: read, not a write
    @(negedge clk); idle(); style = 1; sel = 1; rw = 0; lane_lo = 1; lane_hi = 1; ad_in = 16'hDEAD;
    @(negedge clk); idle();
    rd_word(1, "R5 rw low no write");

    // R6: deselected write and read
    latch(14'h3EFF, 2'b00);
    wr_split(16'hFFFF, 1, 1, 0);
    rd_word(0, "R6 deselected write ignored");
    @(negedge clk); idle(); style = 0; sel = 0; rd = 1;
    @(negedge clk);
    chk("R6 no drive when deselected", 32'(ad_oe), 32'd0);
    idle();

    // R7: latch strobe active during read -> bus released
    @(negedge clk); idle(); style = 0; sel = 1; rd = 1; ale = 1; ad_in = {2'b00, cur};
    @(negedge clk);
    chk("R7 no drive while strobing", 32'(ad_oe), 32'd0);
    idle();
    // R7: write and read requested together -> write only, no drive
    @(negedge clk); idle(); style = 0; sel = 1; rd = 1; wr_lo = 1; ad_in = 16'h0042;
    m_wr(cur, 16'h0042, 1, 0);
    @(negedge clk);
    chk("R7 write beats read", 32'(ad_oe), 32'd0);
    idle();
    rd_word(0, "R7 write landed");

    // R8: control bank vs buffer, buffer aliasing
    latch(14'h3F05, 2'b00);
    wr_split(16'h7711, 1, 1, 1);
    latch(14'h0305, 2'b00);
    wr_split(16'h2288, 1, 1, 1);
    latch(14'h3F05, 2'b00);
    rd_word(0, "R8 control bank separate");
    latch(14'h2105, 2'b00);
    wr_split(16'h6633, 1, 1, 1);
    latch(14'h0105, 2'b00);
    rd_word(0, "R8 buffer wraps by depth");

    // R3: reset returns the latch to word 0
    latch(14'h3F00, 2'b00);
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    cur = 14'h0000;
    rd_word(0, "R3 reset clears address");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: latch(pool(int'($urandom_range(0, 7))), 2'($urandom));
        1: wr_split(16'($urandom), 1'($urandom), 1'($urandom), 1);
        2: wr_lanes(16'($urandom), 1'($urandom), 1'($urandom));
        3: wr_split(16'($urandom), 1'($urandom), 1'($urandom), 0);
        default: rd_word(1'($urandom), "R2 R4 R5 random read back");
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule